// File: doc/BRIEF.md
# Cross-Chip Source Egress Mask Table

This block keeps one egress port mask for each pair of source device and source port in a fabric built from several switch chips. When a frame arrives from another chip, the forwarding path gives the block the frame's source device and source port. One clock later the block returns the mask of local ports that the frame may leave through.

Software programs the table through three registers on a simple register bus:

- **Command register.** It holds a busy flag, a 3-bit opcode and a 9-bit entry pointer. Setting the busy flag starts the operation, and the hardware clears the flag when the operation is done.
- **Data register.** It holds the mask that a single write stores, and it receives the mask that a single read fetches.
- **Mode register.** It holds one bit that selects how the 9-bit pointer is divided between device and port.

The available operations are:

- fill every entry with ones, so that any source may reach any port;
- write one entry from the data register;
- read one entry into the data register.

Top module: `xsrc_mask_table`

## Requirements
- R1: After reset, busy is 0, the command, data and mode registers read 0, and every table entry holds all ones (0x7FF), so every lookup returns 0x7FF.
- R2: The command register (offset 0x0B) reads as {busy[15], opcode[14:12], 3'b000, pointer[8:0]}. The data register (offset 0x0C) reads the 11-bit mask in bits 10:0 with zeros above it. Unmapped offsets read 0.
- R3: A command write with bit 15 set and opcode 3 stores data bits 10:0 into the entry at the pointer. Busy reads 1 for exactly one cycle after the write and then 0.
- R4: A command write with bit 15 set and opcode 4 loads the addressed entry into the data register. The data register changes in the same cycle that busy returns to 0, and it keeps its old value during the busy cycle.
- R5: A command write with bit 15 set and opcode 1 sets all 512 entries to 0x7FF. Busy stays 1 for exactly 512 cycles.
- R6: While busy is 1, writes to the command register and to the data register are ignored.
- R7: With mode 0, a lookup uses the pointer {dev[4:0], port[3:0]}.
- R8: The mode bit is bit 14 of the mode register (offset 0x1D). Its other bits read 0. With mode 1, a lookup uses the pointer {dev[3:0], port[4:0]}.
- R9: The lookup mask is registered. It changes one clock edge after the source inputs change, and not before that edge.
- R10: Opcodes 0, 2, 5, 6 and 7 started with bit 15 set change no entry and leave the data register unchanged. Busy clears after one cycle.
- R11: A command write with bit 15 clear stores the opcode and pointer fields but starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Register offset |
| regWData | input | 16 | Register write data |
| regRData | output | 16 | Register read data for regAddr, combinational |
| lkDev | input | 5 | Lookup source device |
| lkPort | input | 5 | Lookup source port |
| lkMask | output | 11 | Egress mask for the lookup source, one cycle later |

## Verification
A corrupted or misplaced table entry appears at the lookup port one cycle after the forwarding path names that source. A full sweep of every pointer in both modes therefore exposes any entry that was written at the wrong index or that holds the wrong value. A sequencer that stalls or finishes early shows as a busy count other than 1 or 512 cycles. The same fault can leave stale entries behind after a fill. A read that lands a cycle early or late shows as the data register changing in the wrong cycle relative to the falling edge of busy.

// File: rtl/xsrc_mask_pkg.sv
package xsrc_mask_pkg;
  localparam int WIDE_W   = 5;
  localparam int NARROW_W = 4;
  localparam int PTR_W    = WIDE_W + NARROW_W;
  localparam int ENTRIES  = 1 << PTR_W;

  localparam logic [2:0] OP_FILL  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_READ  = 3'd4;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    logic wrOne;
    logic rdOne;
    logic fillOne;
    ptr_t idx;
  } tblStrobe_t;
endpackage

// File: rtl/xsrc_mask_ctrl.sv
module xsrc_mask_ctrl
  import xsrc_mask_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int REG_W = 16,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 5'h0B,
  parameter logic [ADDR_W-1:0] DATA_OFS = 5'h0C,
  parameter logic [ADDR_W-1:0] MISC_OFS = 5'h1D,
  parameter int BUSY_BIT = 15,
  parameter int MODE_BIT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  output logic              busy,
  output logic [2:0]        opReg,
  output ptr_t              ptrReg,
  output logic              modeBit,
  output logic              dataWrEn,
  output tblStrobe_t        strobe
);
  typedef enum logic [1:0] {S_IDLE, S_ONE, S_FILL} state_t;

  localparam ptr_t LAST_IDX = ptr_t'(ENTRIES - 1);

  state_t stateQ;
  ptr_t   fillCnt;
  logic   cmdHit;
  logic   miscHit;

  assign cmdHit   = regWr && (regAddr == CMD_OFS);
  assign miscHit  = regWr && (regAddr == MISC_OFS);
  assign dataWrEn = regWr && (regAddr == DATA_OFS) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= S_IDLE;
      busy    <= 1'b0;
      opReg   <= 3'd0;
      ptrReg  <= '0;
      fillCnt <= '0;
      modeBit <= 1'b0;
    end else begin
      if (miscHit) modeBit <= regWData[MODE_BIT];
      case (stateQ)
        S_IDLE: begin
          if (cmdHit) begin
            opReg  <= regWData[14:12];
            ptrReg <= regWData[PTR_W-1:0];
            if (regWData[BUSY_BIT]) begin
              busy    <= 1'b1;
              fillCnt <= '0;
              stateQ  <= (regWData[14:12] == OP_FILL) ? S_FILL : S_ONE;
            end
          end
        end
        S_ONE: begin
          busy   <= 1'b0;
          stateQ <= S_IDLE;
        end
        S_FILL: begin
          fillCnt <= fillCnt + 1'b1;
          if (fillCnt == LAST_IDX) begin
            busy   <= 1'b0;
            stateQ <= S_IDLE;
          end
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.wrOne   = (stateQ == S_ONE) && (opReg == OP_WRITE);
    strobe.rdOne   = (stateQ == S_ONE) && (opReg == OP_READ);
    strobe.fillOne = (stateQ == S_FILL);
    strobe.idx     = (stateQ == S_FILL) ? fillCnt : ptrReg;
  end

  // R3
  single_op_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && opReg != OP_FILL) |=> !busy);

  // R6
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmdHit) |=> ($stable(opReg) && $stable(ptrReg)));

  // R5
  fill_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.fillOne && fillCnt != LAST_IDX) |=> busy);

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrOne, strobe.rdOne, strobe.fillOne}));
endmodule

// File: rtl/xsrc_mask_datapath.sv
module xsrc_mask_datapath
  import xsrc_mask_pkg::*;
#(
  parameter int MASK_W = 11,
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  tblStrobe_t         strobe,
  input  logic               dataWrEn,
  input  logic [REG_W-1:0]   regWData,
  input  logic               modeBit,
  input  logic [WIDE_W-1:0]  lkDev,
  input  logic [WIDE_W-1:0]  lkPort,
  output logic [MASK_W-1:0]  dataReg,
  output logic [MASK_W-1:0]  lkMask
);
  logic [MASK_W-1:0] tbl [ENTRIES];
  ptr_t lkPtr;
  ptr_t ptrNarrowPort;
  ptr_t ptrWidePort;

  assign ptrNarrowPort = {lkDev[WIDE_W-1:0], lkPort[NARROW_W-1:0]};
  assign ptrWidePort   = {lkDev[NARROW_W-1:0], lkPort[WIDE_W-1:0]};
  assign lkPtr = modeBit ? ptrWidePort : ptrNarrowPort;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '1;
      dataReg <= '0;
      lkMask  <= '1;
    end else begin
      if (strobe.wrOne)   tbl[strobe.idx] <= dataReg;
      if (strobe.fillOne) tbl[strobe.idx] <= '1;
      if (strobe.rdOne)   dataReg <= tbl[strobe.idx];
      else if (dataWrEn)  dataReg <= regWData[MASK_W-1:0];
      lkMask <= tbl[lkPtr];
    end
  end

  // R5
  fill_entry_ones_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.fillOne |=> (tbl[$past(strobe.idx)] == '1));

  // R3
  write_entry_lands_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.wrOne |=> (tbl[$past(strobe.idx)] == $past(dataReg)));
endmodule

// File: rtl/xsrc_mask_table.sv
module xsrc_mask_table
  import xsrc_mask_pkg::*;
#(
  parameter int MASK_W = 11,
  parameter int ADDR_W = 5,
  parameter int REG_W = 16,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 5'h0B,
  parameter logic [ADDR_W-1:0] DATA_OFS = 5'h0C,
  parameter logic [ADDR_W-1:0] MISC_OFS = 5'h1D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  output logic [REG_W-1:0]  regRData,
  input  logic [4:0]        lkDev,
  input  logic [4:0]        lkPort,
  output logic [MASK_W-1:0] lkMask
);
  localparam int MODE_BIT = 14;
  localparam int BUSY_BIT = 15;

  logic        busy;
  logic [2:0]  opReg;
  ptr_t        ptrReg;
  logic        modeBit;
  logic        dataWrEn;
  tblStrobe_t  strobe;
  logic [MASK_W-1:0] dataReg;

  xsrc_mask_ctrl #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS),
    .MISC_OFS(MISC_OFS), .BUSY_BIT(BUSY_BIT), .MODE_BIT(MODE_BIT)
  ) ctrl (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .busy(busy), .opReg(opReg), .ptrReg(ptrReg), .modeBit(modeBit),
    .dataWrEn(dataWrEn), .strobe(strobe)
  );

  xsrc_mask_datapath #(.MASK_W(MASK_W), .REG_W(REG_W)) dp (
    .clk(clk), .rst(rst), .strobe(strobe), .dataWrEn(dataWrEn),
    .regWData(regWData), .modeBit(modeBit), .lkDev(lkDev), .lkPort(lkPort),
    .dataReg(dataReg), .lkMask(lkMask)
  );

  always_comb begin
    regRData = '0;
    if (regAddr == CMD_OFS) begin
      regRData[BUSY_BIT]    = busy;
      regRData[14:12]       = opReg;
      regRData[PTR_W-1:0]   = ptrReg;
    end else if (regAddr == DATA_OFS) begin
      regRData[MASK_W-1:0]  = dataReg;
    end else if (regAddr == MISC_OFS) begin
      regRData[MODE_BIT]    = modeBit;
    end
  end
endmodule

// File: tb/xsrc_mask_table_test.sv
module xsrc_mask_table_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] CMD  = 5'h0B;
  localparam logic [4:0] DATA = 5'h0C;
  localparam logic [4:0] MISC = 5'h1D;

  logic clk = 0;
  logic rst = 1;
  logic regWr = 0;
  logic [4:0] regAddr = 0;
  logic [15:0] regWData = 0;
  logic [15:0] regRData;
  logic [4:0] lkDev = 0;
  logic [4:0] lkPort = 0;
  logic [10:0] lkMask;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xsrc_mask_table uut (
    .clk(clk), .rst(rst), .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .regRData(regRData), .lkDev(lkDev), .lkPort(lkPort), .lkMask(lkMask)
  );

  function automatic logic [10:0] pattern(input int p);
    return 11'((p * 37 + 5) & 16'h7FF);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [15:0] d);
    regWr = 1; regAddr = a; regWData = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [15:0] v);
    regAddr = a;
    #1;
    v = regRData;
  endtask

  task automatic look(input int dev, input int port, output logic [10:0] m);
    lkDev = 5'(dev); lkPort = 5'(port);
    @(negedge clk);
    m = lkMask;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [10:0] m;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    busRead(CMD, v);  check("R1 cmd", v, 16'h0000);
    busRead(DATA, v); check("R1 data", v, 16'h0000);
    busRead(MISC, v); check("R1 mode", v, 16'h0000);
    for (int p = 0; p < 512; p++) begin
      look(p >> 4, p & 15, m);
      check("R1 reset entry", 16'(m), 16'h07FF);
    end
    // R2 unmapped offset
    busRead(5'h03, v); check("R2 unmapped", v, 16'h0000);

    // R11 no start
    busWrite(CMD, 16'h3055);
    busRead(CMD, v); check("R11 stored no busy", v, 16'h3055);
    @(negedge clk);
    busRead(CMD, v); check("R11 still idle", v, 16'h3055);
    look(5, 5, m); check("R11 entry untouched", 16'(m), 16'h07FF);

    // R3 write every entry
    for (int p = 0; p < 512; p++) begin
      busWrite(DATA, 16'(pattern(p)));
      busWrite(CMD, 16'hB000 | 16'(p));
      busRead(CMD, v); check("R3 busy during write", v, 16'hB000 | 16'(p));
      @(negedge clk);
      busRead(CMD, v); check("R3 busy cleared", v, 16'h3000 | 16'(p));
    end
    // R7 mode 0 sweep
    for (int p = 0; p < 512; p++) begin
      look(p >> 4, p & 15, m);
      check("R7 mode0 lookup", 16'(m), 16'(pattern(p)));
    end
    // R9 latency
    lkDev = 5'd1; lkPort = 5'd2;
    #1; check("R9 before edge", 16'(lkMask), 16'(pattern(511)));
    @(negedge clk);
    check("R9 after edge", 16'(lkMask), 16'(pattern(18)));

    // R8 mode register
    busWrite(MISC, 16'hFFFF);
    busRead(MISC, v); check("R8 mode bit only", v, 16'h4000);
    for (int p = 0; p < 512; p++) begin
      look(p >> 5, p & 31, m);
      check("R8 mode1 lookup", 16'(m), 16'(pattern(p)));
    end
    busWrite(MISC, 16'h0000);
    busRead(MISC, v); check("R8 mode cleared", v, 16'h0000);

    // R4 single read
    for (int p = 0; p < 40; p++) begin
      int q;
      q = (p < 39) ? p * 13 : 511;
      busWrite(DATA, 16'h0000);
      busWrite(CMD, 16'hC000 | 16'(q));
      busRead(DATA, v); check("R4 data held while busy", v, 16'h0000);
      @(negedge clk);
      busRead(CMD, v); check("R4 busy cleared", v, 16'h4000 | 16'(q));
      busRead(DATA, v); check("R4 read data", v, 16'(pattern(q)));
    end

    // R10 undefined opcodes
    for (int op = 0; op < 8; op++) begin
      if (op == 1 || op == 3 || op == 4) continue;
      busWrite(DATA, 16'h02AA);
      busWrite(CMD, 16'h8000 | 16'(op << 12) | 16'd7);
      @(negedge clk);
      busRead(CMD, v); check("R10 busy cleared", v, 16'(op << 12) | 16'd7);
      busRead(DATA, v); check("R10 data kept", v, 16'h02AA);
      look(0, 7, m); check("R10 entry kept", 16'(m), 16'(pattern(7)));
    end

    // R5 fill and R6 ignored writes
    busWrite(CMD, 16'h9000);
    cnt = 0;
    busRead(CMD, v); if (v[15]) cnt++;
    busWrite(CMD, 16'hB005);
    busRead(CMD, v); if (v[15]) cnt++;
    busWrite(DATA, 16'h00F0);
    busRead(CMD, v); if (v[15]) cnt++;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      busRead(CMD, v);
      if (v[15]) cnt++; else break;
    end
    check("R5 fill busy cycles", 16'(cnt), 16'd512);
    busRead(CMD, v);  check("R6 cmd write ignored", v, 16'h1000);
    busRead(DATA, v); check("R6 data write ignored", v, 16'h02AA);
    for (int p = 0; p < 512; p++) begin
      look(p >> 4, p & 15, m);
      check("R5 filled entry", 16'(m), 16'h07FF);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule